// File: doc/BRIEF.md
# Byte-Programmed PWM With Auto-Off

A single-channel pulse-width modulator whose settings arrive one byte at a time over a simple write port: a byte address, a write strobe and a data byte. Period and duty are 16-bit counts of an 8 MHz base tick (125 ns). The base tick reaches the block as a one-cycle enable. Each 16-bit value is split into a high byte, which is only held aside, and a low byte. Writing the low byte joins it with the held high byte, and the new value is used at once.

An enable bit starts and stops the output. A 16-bit auto-off value, counted in milliseconds, clears the enable bit when its countdown runs out. The all-ones value switches automatic turn-off off. The output is active high. It is high for the first `duty` ticks of each period and low for the rest.

Because period and duty are committed by separate writes, the block can briefly run with a duty that is larger than the period. In that case the output simply stays high for the whole cycle.

Top module: `byte_pwm`

## Requirements
- R1: After reset the period, duty, auto-off value and enable bit are all zero, and `pwm_o` is low.
- R2: A write to the period-high (0xA5) or duty-high (0xA7) address only holds the byte aside. The active period or duty and the output pattern do not change.
- R3: A write to the period-low (0xA4) or duty-low (0xA6) address sets the active value to {held high byte, written byte} from the next clock on.
- R4: While enabled with a non-zero period P, a counter advances once per base tick from 0 to P-1 and then wraps to 0. `pwm_o` is high exactly while the counter is below the duty D, so any P consecutive ticks hold min(D,P) high ticks.
- R5: When the duty is equal to or larger than the period, `pwm_o` stays high for the whole cycle.
- R6: A period of 0 holds `pwm_o` low and the counter at 0.
- R7: Address 0xA3 bit 0 is the enable. Writing 0 forces `pwm_o` low and holds the counter at 0. Writing 1 starts output from counter value 0.
- R8: An auto-off value of 0xFFFF (high byte at 0xA1, low byte at 0xA2, each written directly) never clears the enable.
- R9: Any other auto-off value N clears the enable (N+1)·TICKS_PER_MS base ticks after the last write to 0xA1, 0xA2 or 0xA3. Each such write restarts the countdown.
- R10: Writes to any address other than 0xA1 to 0xA7 change nothing.
- R11: A newly committed period or duty acts on the very next comparison, without waiting for the current cycle to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle base tick enable (8 MHz rate) |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_data_i | input | 8 | Write data byte |
| pwm_o | output | 1 | Active-high PWM output |

## Verification
A bench model of the registers, tick counter and auto-off countdown predicts `pwm_o` on every cycle. This model runs under random writes that land on all seven addresses and on unmapped ones, with irregular base ticks. That run tells apart commit-order and wrap-point errors that fixed patterns hide. Directed patterns count high ticks over a full period for duty below, equal to and above the period, which separates the compare boundary from the wrap boundary. Other directed cases change duty in the middle of a cycle, restart the counter through the enable bit, and place the auto-off expiry to the exact cycle with and without a restart.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  localparam int BYTE_W = 8;
  localparam int VAL_W  = 2 * BYTE_W;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_AOFF_HI = 8'hA1;
  localparam logic [ADDR_W-1:0] A_AOFF_LO = 8'hA2;
  localparam logic [ADDR_W-1:0] A_EN      = 8'hA3;
  localparam logic [ADDR_W-1:0] A_PER_LO  = 8'hA4;
  localparam logic [ADDR_W-1:0] A_PER_HI  = 8'hA5;
  localparam logic [ADDR_W-1:0] A_DUTY_LO = 8'hA6;
  localparam logic [ADDR_W-1:0] A_DUTY_HI = 8'hA7;

  localparam logic [VAL_W-1:0] AOFF_NEVER = '1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_AOFF_HI, SEL_AOFF_LO, SEL_EN,
    SEL_PER_LO, SEL_PER_HI, SEL_DUTY_LO, SEL_DUTY_HI
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      A_AOFF_HI: return SEL_AOFF_HI;
      A_AOFF_LO: return SEL_AOFF_LO;
      A_EN:      return SEL_EN;
      A_PER_LO:  return SEL_PER_LO;
      A_PER_HI:  return SEL_PER_HI;
      A_DUTY_LO: return SEL_DUTY_LO;
      A_DUTY_HI: return SEL_DUTY_HI;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/bpwm_split_reg.sv
module bpwm_split_reg
  import bpwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_we_i,
  input  logic             lo_we_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [VAL_W-1:0]  val_o
);
  logic [BYTE_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      val_o   <= '0;
    end else begin
      if (hi_we_i) stage_q <= data_i;
      if (lo_we_i) val_o   <= {stage_q, data_i};
    end
  end

  // R3
  commit_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> val_o == {$past(stage_q), $past(data_i)});

  // R2
  stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && !lo_we_i) |=> $stable(val_o));
endmodule

// File: rtl/bpwm_regs.sv
module bpwm_regs
  import bpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              expire_i,
  output logic [VAL_W-1:0]  period_o,
  output logic [VAL_W-1:0]  duty_o,
  output logic [VAL_W-1:0]  aoff_o,
  output logic [VAL_W-1:0]  aoff_next_o,
  output logic              en_o,
  output logic              reload_o
);
  localparam int N_SPLIT = 2;  // 0: period, 1: duty

  reg_sel_e sel;
  assign sel = wr_en_i ? decode_addr(wr_addr_i) : SEL_NONE;

  logic [N_SPLIT-1:0] hi_we, lo_we;
  logic [VAL_W-1:0]   split_val [N_SPLIT];

  assign hi_we = {sel == SEL_DUTY_HI, sel == SEL_PER_HI};
  assign lo_we = {sel == SEL_DUTY_LO, sel == SEL_PER_LO};

  for (genvar g = 0; g < N_SPLIT; g++) begin : g_split
    bpwm_split_reg u_split (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hi_we_i (hi_we[g]),
      .lo_we_i (lo_we[g]),
      .data_i  (wr_data_i),
      .val_o   (split_val[g])
    );
  end

  assign period_o = split_val[0];
  assign duty_o   = split_val[1];

  // auto-off bytes land directly, no staging
  always_comb begin
    aoff_next_o = aoff_o;
    if (sel == SEL_AOFF_HI) aoff_next_o[VAL_W-1:BYTE_W] = wr_data_i;
    if (sel == SEL_AOFF_LO) aoff_next_o[BYTE_W-1:0]     = wr_data_i;
  end

  assign reload_o = (sel == SEL_AOFF_HI) || (sel == SEL_AOFF_LO) || (sel == SEL_EN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aoff_o <= '0;
      en_o   <= 1'b0;
    end else begin
      aoff_o <= aoff_next_o;
      if (sel == SEL_EN) en_o <= wr_data_i[0];
      else if (expire_i) en_o <= 1'b0;
    end
  end

  // R10
  unmapped_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && decode_addr(wr_addr_i) == SEL_NONE)
      |=> ($stable(period_o) && $stable(duty_o) && $stable(aoff_o)));

  // R7
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_EN) |=> en_o == $past(wr_data_i[0]));
endmodule

// File: rtl/bpwm_core.sv
module bpwm_core
  import bpwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [VAL_W-1:0] period_i,
  input  logic [VAL_W-1:0] duty_i,
  output logic             pwm_o
);
  logic [VAL_W-1:0] cnt_q;
  logic             at_wrap;

  // >= so a shrunken period wraps on the next tick
  assign at_wrap = cnt_q >= (period_i - VAL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || period_i == '0) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_wrap ? '0 : cnt_q + VAL_W'(1);
    end
  end

  assign pwm_o = en_i && (period_i != '0) && (cnt_q < duty_i);

  // R6
  zero_period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |=> cnt_q == '0);

  // R4
  counter_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && period_i != '0 && tick_i && cnt_q >= period_i - VAL_W'(1))
      |=> cnt_q == '0);
endmodule

// File: rtl/bpwm_autooff.sv
module bpwm_autooff
  import bpwm_pkg::*;
#(
  parameter int TICKS_PER_MS = 8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [VAL_W-1:0] aoff_i,
  input  logic [VAL_W-1:0] aoff_next_i,
  input  logic             reload_i,
  output logic             expire_o
);
  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [VAL_W-1:0] rem_q;
  logic             run, ms_strobe;

  assign run       = en_i && (aoff_i != AOFF_NEVER) && !reload_i;
  assign ms_strobe = run && tick_i && (pre_q == PRE_LAST);
  assign expire_o  = ms_strobe && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      rem_q <= '0;
    end else if (reload_i) begin
      pre_q <= '0;
      rem_q <= aoff_next_i;
    end else if (run && tick_i) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (rem_q != '0) rem_q <= rem_q - VAL_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/byte_pwm.sv
module byte_pwm
  import bpwm_pkg::*;
#(
  parameter int TICKS_PER_MS = 8000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic       pwm_o
);
  logic [VAL_W-1:0] period, duty, aoff, aoff_next;
  logic             en, reload, expire;

  bpwm_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .expire_i    (expire),
    .period_o    (period),
    .duty_o      (duty),
    .aoff_o      (aoff),
    .aoff_next_o (aoff_next),
    .en_o        (en),
    .reload_o    (reload)
  );

  bpwm_autooff #(.TICKS_PER_MS(TICKS_PER_MS)) u_autooff (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .en_i        (en),
    .aoff_i      (aoff),
    .aoff_next_i (aoff_next),
    .reload_i    (reload),
    .expire_o    (expire)
  );

  bpwm_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .en_i     (en),
    .period_i (period),
    .duty_i   (duty),
    .pwm_o    (pwm_o)
  );

  // R7
  disable_forces_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_EN && !wr_data_i[0]) |=> !pwm_o);

  // R8
  never_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && aoff == AOFF_NEVER && !(wr_en_i && wr_addr_i == A_EN)) |=> en);

  // R9
  expire_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !(wr_en_i && wr_addr_i == A_EN)) |=> !en);
endmodule

// File: tb/byte_pwm_bench.sv
module byte_pwm_bench;
  localparam int TPM = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       pwm_o;

  byte_pwm #(.TICKS_PER_MS(TPM)) u_byte_pwm (.*);

  always #10 clk_i = ~clk_i;

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 1'b0;
  bit    checking = 1'b0;
  string cur_req = "R4";

  // reference model
  logic [15:0] m_per, m_duty, m_aoff, m_rem, m_cnt;
  logic [7:0]  m_phi, m_dhi;
  logic        m_en, m_reload, m_run, m_expire, m_en_old;
  logic [15:0] m_per_old, m_aoff_old;
  int          m_pre;

  function automatic bit exp_pwm(input bit en, input logic [15:0] per,
                                 input logic [15:0] duty, input logic [15:0] cnt);
    return en && per != 16'd0 && cnt < duty;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_per = 0; m_duty = 0; m_aoff = 0; m_rem = 0; m_cnt = 0;
      m_phi = 0; m_dhi = 0; m_en = 0; m_pre = 0;
    end else begin
      m_en_old   = m_en;
      m_per_old  = m_per;
      m_aoff_old = m_aoff;
      m_reload = wr_en_i && (wr_addr_i == 8'hA1 || wr_addr_i == 8'hA2 || wr_addr_i == 8'hA3);
      m_run    = m_en_old && m_aoff_old != 16'hFFFF && !m_reload;
      m_expire = m_run && tick_i && m_pre == TPM - 1 && m_rem == 0;
      if (wr_en_i) begin
        case (wr_addr_i)
          8'hA1: m_aoff[15:8] = wr_data_i;
          8'hA2: m_aoff[7:0]  = wr_data_i;
          8'hA3: m_en         = wr_data_i[0];
          8'hA4: m_per        = {m_phi, wr_data_i};
          8'hA5: m_phi        = wr_data_i;
          8'hA6: m_duty       = {m_dhi, wr_data_i};
          8'hA7: m_dhi        = wr_data_i;
          default: ;
        endcase
      end
      if (!(wr_en_i && wr_addr_i == 8'hA3) && m_expire) m_en = 0;
      if (m_reload) begin
        m_rem = m_aoff; m_pre = 0;
      end else if (m_run && tick_i) begin
        if (m_pre == TPM - 1) begin
          m_pre = 0;
          if (m_rem != 0) m_rem = m_rem - 1;
        end else m_pre = m_pre + 1;
      end
      if (!m_en_old || m_per_old == 0) m_cnt = 0;
      else if (tick_i) m_cnt = (m_cnt >= m_per_old - 1) ? 16'd0 : m_cnt + 1;
    end
  end

  always @(negedge clk_i) begin
    if (checking && rst_ni && !done) begin
      vectors++;
      if (pwm_o !== exp_pwm(m_en, m_per, m_duty, m_cnt)) begin
        errors++;
        $display("FAIL %s model: pwm_o got %0b exp %0b at %0t", cur_req, pwm_o,
                 exp_pwm(m_en, m_per, m_duty, m_cnt), $time);
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string req);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pwm_o got %0b exp %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string req);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s high count got %0d exp %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_o);
      @(negedge clk_i);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    finish_run();
  end

  initial begin
    int h;
    bit [9:0] pat;
    repeat (3) @(negedge clk_i);
    chk(pwm_o, 1'b0, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    checking = 1'b1;
    chk(pwm_o, 1'b0, "R1");

    cur_req = "R6";
    wr(8'hA1, 8'hFF); wr(8'hA2, 8'hFF);
    wr(8'hA3, 8'h01);
    repeat (3) @(negedge clk_i);
    chk(pwm_o, 1'b0, "R6");
    wr(8'hA7, 8'h00); wr(8'hA6, 8'h03);
    chk(pwm_o, 1'b0, "R6");

    cur_req = "R3";
    wr(8'hA5, 8'h00);
    chk(pwm_o, 1'b0, "R2");
    wr(8'hA4, 8'd10);
    count_high(10, h); chk_int(h, 3, "R3");
    count_high(10, h); chk_int(h, 3, "R4");

    cur_req = "R2";
    wr(8'hA5, 8'h01);
    count_high(10, h); chk_int(h, 3, "R2");
    wr(8'hA7, 8'h02);
    count_high(10, h); chk_int(h, 3, "R2");
    wr(8'hA5, 8'h00); wr(8'hA7, 8'h00);

    cur_req = "R10";
    wr(8'hA0, 8'h55); wr(8'hA8, 8'h00); wr(8'h00, 8'h00); wr(8'h23, 8'h00);
    count_high(10, h); chk_int(h, 3, "R10");

    cur_req = "R5";
    wr(8'hA6, 8'd20);
    count_high(10, h); chk_int(h, 10, "R5");
    wr(8'hA6, 8'd10);
    count_high(10, h); chk_int(h, 10, "R5");

    cur_req = "R7";
    wr(8'hA6, 8'd3);
    wr(8'hA3, 8'h00);
    count_high(10, h); chk_int(h, 0, "R7");
    wr(8'hA3, 8'h01);
    for (int i = 0; i < 10; i++) begin
      pat[9 - i] = pwm_o;
      @(negedge clk_i);
    end
    chk_int(int'(pat), int'(10'b1110000000), "R7");

    cur_req = "R11";
    wr(8'hA4, 8'd100); wr(8'hA6, 8'd50);
    wr(8'hA3, 8'h00); wr(8'hA3, 8'h01);
    repeat (20) @(negedge clk_i);
    chk(pwm_o, 1'b1, "R11");
    wr(8'hA6, 8'd5);
    chk(pwm_o, 1'b0, "R11");
    wr(8'hA6, 8'd60);
    chk(pwm_o, 1'b1, "R11");

    cur_req = "R8";
    wr(8'hA6, 8'd200);
    repeat (200) @(negedge clk_i);
    chk(pwm_o, 1'b1, "R8");

    cur_req = "R9";
    wr(8'hA1, 8'h00);
    wr(8'hA2, 8'h02);
    repeat (14) @(negedge clk_i);
    chk(pwm_o, 1'b1, "R9");
    @(negedge clk_i);
    chk(pwm_o, 1'b0, "R9");
    wr(8'hA3, 8'h01);
    repeat (8) @(negedge clk_i);
    wr(8'hA2, 8'h02);
    repeat (14) @(negedge clk_i);
    chk(pwm_o, 1'b1, "R9");
    @(negedge clk_i);
    chk(pwm_o, 1'b0, "R9");

    cur_req = "R4";
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 6000; i++) begin
      tick_i = ($urandom % 4) != 0;
      if (($urandom % 5) == 0) begin
        logic [7:0] a, d;
        case ($urandom % 9)
          0: a = 8'hA1; 1: a = 8'hA2; 2: a = 8'hA3; 3: a = 8'hA4;
          4: a = 8'hA5; 5: a = 8'hA6; 6: a = 8'hA7; 7: a = 8'hA0;
          default: a = 8'($urandom);
        endcase
        d = 8'($urandom);
        if (a == 8'hA5 || a == 8'hA7) d = 8'($urandom % 2);
        if (a == 8'hA1) d = ($urandom % 2) ? 8'hFF : 8'h00;
        if (a == 8'hA4 || a == 8'hA6) d = 8'($urandom % 40);
        if (a == 8'hA3) d = ($urandom % 4) ? 8'h01 : 8'h00;
        wr(a, d);
      end else begin
        @(negedge clk_i);
      end
    end
    tick_i = 1'b1;
    finish_run();
  end
endmodule